// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block is one bidirectional parallel port of parameterised width, with two control lines. A direction register picks, per pin, whether the pin is an output or an input. An output register supplies the level driven on output pins. An input path can either follow the pins or hold a snapshot that was taken on an edge of control line C1. C1 is an edge-sensitive input that raises its own interrupt flag. Control line C2 has four uses:

- an edge-sensitive interrupt input;
- a handshake output that is pulled low by a data-register access and released by the next active C1 edge;
- a one-cycle pulse output;
- a fixed-level output.

A processor talks to the block through a single-cycle register strobe. The strobe carries a select, a read/write flag, a 4-bit address and a data bus. The data register has two addresses. The primary address performs the handshake and clears the flags. The alias address reaches the same storage with no side effects. The pins, C1 and C2 pass through two-flop synchronisers before use. The two flags leave the block as separate level outputs.

Register map (address: content):

| Address | Register |
|---|---|
| 0 | data register |
| 1 | direction register |
| 2 | control register |
| 3 | flag register |
| 4 | data register alias |

Control register fields:

- Bit 0 selects the C1 active edge: 1 for rising, 0 for falling.
- Bits 3:1 hold the C2 mode.
- Bit 4 enables input latching.

The flag register holds the C1 flag in bit 0 and the C2 flag in bit 1. Reads of other addresses return zero, and writes to them do nothing.

Top module: `hspp_port`

## Requirements
- R1: A direction bit of 1 makes `pin_oe` high for that pin, and `pin_out` then carries the output register bit. A direction bit of 0 gives `pin_oe` 0 and `pin_out` 0. A value written to the output register is still stored, and it appears on the pin once the direction bit is set.
- R2: A read of the data register returns the output register bit for each output pin. For each input pin it returns the synchronised pin level, which follows a pin change after two clock edges.
- R3: Control bit 0 selects the C1 active edge (1 rising, 0 falling). An active edge sets the C1 flag (flag bit 0 and `irq_c1`) on the third rising clock edge after `c1_in` changes. An edge of the opposite direction does nothing.
- R4: When control bit 4 is 1, an active C1 edge captures the synchronised input pins into the input register. Data reads return the captured value until the first data read after the capture. After that read, data reads follow the pins again.
- R5: The C2 mode (control bits 3:1) has four input codes: 000 and 001 react to a falling edge, and 010 and 011 react to a rising edge. In these modes an active `c2_in` edge sets the C2 flag (flag bit 1 and `irq_c2`), and `c2_oe` is 0.
- R6: Any read or write at address 0 clears the C1 flag. It also clears the C2 flag, except in modes 001 and 011, where the C2 flag survives the access.
- R7: Reading address 3 returns the flags without changing them. Writing address 3 clears each flag whose data bit is 1. A flag-setting event in the same cycle takes priority over any clear.
- R8: In mode 100, any read or write at address 0 drives `c2_out` low from the next cycle. The next active C1 edge returns it high and sets the C1 flag.
- R9: In mode 101, a read or write at address 0 drives `c2_out` low for exactly one clock cycle.
- R10: Mode 110 holds `c2_out` low and mode 111 holds it high. In modes 1xx, `c2_oe` is 1.
- R11: Address 4 reads and writes the same data register as address 0. It drives no handshake or pulse on C2 and clears no flag.
- R12: After reset, every register reads zero and `pin_oe`, `pin_out`, `c2_oe` and both flags are 0, while `c2_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register strobe, one access per cycle it is high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, valid while cs and rw are high |
| pin_in | input | W | Pin levels from the pads |
| pin_out | output | W | Pin drive levels |
| pin_oe | output | W | Pin output enables |
| c1_in | input | 1 | Control line C1 |
| c2_in | input | 1 | Control line C2 input level |
| c2_out | output | 1 | Control line C2 drive level |
| c2_oe | output | 1 | Control line C2 output enable |
| irq_c1 | output | 1 | C1 interrupt flag |
| irq_c2 | output | 1 | C2 interrupt flag |

## Verification
A stuck or missed latch state shows up as stale data on the very next data read. Once that read has happened, it shows up again as data that fails to follow the pins. A wrong handshake state shows on `c2_out` one cycle after the data access, or three cycles after the releasing C1 edge. A flag that is cleared by the wrong access, or not cleared at all, is visible on `irq_c1` or `irq_c2` in the cycle after that access. The bench reads the flag register around every alias and independent-mode access, so wrongly cleared flags are seen right away.

// File: rtl/hspp_pkg.sv
package hspp_pkg;
  typedef enum logic [2:0] {
    C2_IN_FALL  = 3'b000,
    C2_IND_FALL = 3'b001,
    C2_IN_RISE  = 3'b010,
    C2_IND_RISE = 3'b011,
    C2_HSHAKE   = 3'b100,
    C2_PULSE    = 3'b101,
    C2_LOW      = 3'b110,
    C2_HIGH     = 3'b111
  } c2_mode_e;

  localparam logic [3:0] A_DATA  = 4'd0;
  localparam logic [3:0] A_DIR   = 4'd1;
  localparam logic [3:0] A_CTRL  = 4'd2;
  localparam logic [3:0] A_FLAGS = 4'd3;
  localparam logic [3:0] A_ALIAS = 4'd4;

  // pick the rising or falling event according to the select bit
  function automatic logic edge_hit(input logic rise, input logic fall, input logic pick_rise);
    return pick_rise ? rise : fall;
  endfunction

  // C2 modes that react to an edge on c2_in
  function automatic logic c2_is_input(input c2_mode_e m);
    return ~m[2];
  endfunction

  // input modes whose flag survives a data access
  function automatic logic c2_is_indep(input c2_mode_e m);
    return ~m[2] & m[0];
  endfunction
endpackage

// File: rtl/hspp_sync.sv
module hspp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/hspp_inreg.sv
module hspp_inreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_s,
  input  logic [W-1:0] out_reg,
  input  logic [W-1:0] dir,
  input  logic         latch_en,
  input  logic         capture,
  input  logic         release_rd,
  output logic [W-1:0] view
);
  logic         latched;
  logic [W-1:0] held;
  logic [W-1:0] src;

  // output bits read back the register, input bits the selected source
  function automatic logic [W-1:0] merge(input logic [W-1:0] d, input logic [W-1:0] o,
                                         input logic [W-1:0] s);
    return (d & o) | (~d & s);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched <= 1'b0;
      held    <= '0;
    end else if (capture && latch_en) begin
      latched <= 1'b1;
      held    <= pins_s;
    end else if (release_rd) begin
      latched <= 1'b0;
    end
  end

  assign src  = (latched && latch_en) ? held : pins_s;
  assign view = merge(dir, out_reg, src);
endmodule

// File: rtl/hspp_c2ctl.sv
module hspp_c2ctl
  import hspp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  c2_mode_e mode,
  input  logic     acc_norm,
  input  logic     c1_evt,
  input  logic     c2_rise,
  input  logic     c2_fall,
  input  logic     flag_wclr,
  output logic     c2_evt,
  output logic     c2_out,
  output logic     c2_oe,
  output logic     c2_flag
);
  logic c2_q;
  logic flag_clr;

  assign c2_evt   = c2_is_input(mode) & edge_hit(c2_rise, c2_fall, mode[1]);
  assign flag_clr = (acc_norm & ~c2_is_indep(mode)) | flag_wclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q <= 1'b1;
    end else begin
      unique case (mode)
        C2_HSHAKE: begin
          if (acc_norm)    c2_q <= 1'b0;
          else if (c1_evt) c2_q <= 1'b1;
        end
        C2_PULSE: c2_q <= ~acc_norm;
        C2_LOW:   c2_q <= 1'b0;
        default:  c2_q <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        c2_flag <= 1'b0;
    else if (c2_evt)   c2_flag <= 1'b1;
    else if (flag_clr) c2_flag <= 1'b0;
  end

  assign c2_out = c2_q;
  assign c2_oe  = mode[2];
endmodule

// File: rtl/hspp_port.sv
module hspp_port
  import hspp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs,
  input  logic         rw,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         c1_in,
  input  logic         c2_in,
  output logic         c2_out,
  output logic         c2_oe,
  output logic         irq_c1,
  output logic         irq_c2
);
  localparam int CTRL_W = 5;

  logic [W-1:0] out_reg, dir_reg, pins_s, pins_r, pins_f, view;
  logic [1:0]   ctl_s, ctl_r, ctl_f;
  logic         c1_rise_sel, latch_en, c1_flag, c2_flag, c2_evt;
  c2_mode_e     c2_mode;

  // named access events
  logic wr, rd, acc_norm, acc_alias, data_wr, data_rd, flag_wr, c1_evt;
  assign wr        = cs & ~rw;
  assign rd        = cs & rw;
  assign acc_norm  = cs & (addr == A_DATA);
  assign acc_alias = cs & (addr == A_ALIAS);
  assign data_wr   = wr & (acc_norm | acc_alias);
  assign data_rd   = rd & (acc_norm | acc_alias);
  assign flag_wr   = wr & (addr == A_FLAGS);

  hspp_sync #(.W(W)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s), .rise(pins_r), .fall(pins_f)
  );

  hspp_sync #(.W(2)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({c2_in, c1_in}), .q(ctl_s), .rise(ctl_r), .fall(ctl_f)
  );

  assign c1_evt = edge_hit(ctl_r[0], ctl_f[0], c1_rise_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_reg     <= '0;
      dir_reg     <= '0;
      c1_rise_sel <= 1'b0;
      c2_mode     <= C2_IN_FALL;
      latch_en    <= 1'b0;
    end else if (wr) begin
      if (data_wr)         out_reg <= wdata;
      if (addr == A_DIR)   dir_reg <= wdata;
      if (addr == A_CTRL) begin
        c1_rise_sel <= wdata[0];
        c2_mode     <= c2_mode_e'(wdata[3:1]);
        latch_en    <= wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          c1_flag <= 1'b0;
    else if (c1_evt)                     c1_flag <= 1'b1;
    else if (acc_norm || (flag_wr && wdata[0])) c1_flag <= 1'b0;
  end

  hspp_inreg #(.W(W)) u_inreg (
    .clk(clk), .rst_n(rst_n), .pins_s(pins_s), .out_reg(out_reg), .dir(dir_reg),
    .latch_en(latch_en), .capture(c1_evt), .release_rd(data_rd), .view(view)
  );

  hspp_c2ctl u_c2 (
    .clk(clk), .rst_n(rst_n), .mode(c2_mode), .acc_norm(acc_norm), .c1_evt(c1_evt),
    .c2_rise(ctl_r[1]), .c2_fall(ctl_f[1]), .flag_wclr(flag_wr & wdata[1]),
    .c2_evt(c2_evt), .c2_out(c2_out), .c2_oe(c2_oe), .c2_flag(c2_flag)
  );

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        A_DATA, A_ALIAS: rdata = view;
        A_DIR:           rdata = dir_reg;
        A_CTRL:          rdata = W'({latch_en, c2_mode, c1_rise_sel});
        A_FLAGS:         rdata = W'({c2_flag, c1_flag});
        default:         rdata = '0;
      endcase
    end
  end

  assign pin_out = out_reg & dir_reg;
  assign pin_oe  = dir_reg;
  assign irq_c1  = c1_flag;
  assign irq_c2  = c2_flag;

  logic unused_ok;
  assign unused_ok = ^{pins_r, pins_f, ctl_s, c2_evt, CTRL_W[0]};
endmodule

// File: rtl/hspp_port_chk.sv
module hspp_port_chk
  import hspp_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs,
  input logic         rw,
  input logic [3:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] pin_oe,
  input logic         c2_out,
  input logic         irq_c1,
  input logic         acc_norm,
  input logic         acc_alias,
  input logic         c1_evt,
  input c2_mode_e     mode
);
  p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rw && addr == A_DIR) |=> (pin_oe == $past(wdata)));

  p_c1_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c1_evt |=> irq_c1);

  p_hshake_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C2_HSHAKE && acc_norm) |=> !c2_out);

  p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C2_PULSE && !c2_out && !acc_norm) |=> c2_out);

  p_fixed_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == C2_LOW) |=> !c2_out);

  p_alias_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_alias && irq_c1) |=> irq_c1);
endmodule

bind hspp_port hspp_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
  .pin_oe(pin_oe), .c2_out(c2_out), .irq_c1(irq_c1), .acc_norm(acc_norm),
  .acc_alias(acc_alias), .c1_evt(c1_evt), .mode(c2_mode)
);

// File: tb/hspp_port_test.sv
module hspp_port_test;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, rw = 1'b0;
  logic [3:0] addr = '0;
  logic [W-1:0] wdata = '0, pin_in = '0;
  logic c1_in = 1'b0, c2_in = 1'b0;
  logic [W-1:0] rdata, pin_out, pin_oe;
  logic c2_out, c2_oe, irq_c1, irq_c2;
  int checks = 0, errors = 0;
  logic [W-1:0] rv;

  always #2 clk = ~clk;

  hspp_port #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .c1_in(c1_in), .c2_in(c2_in),
    .c2_out(c2_out), .c2_oe(c2_oe), .irq_c1(irq_c1), .irq_c2(irq_c2)
  );

  // {dir, out, pins, expected read}
  localparam logic [31:0] VEC [6] = '{
    32'hFF_A5_00_A5, 32'h00_A5_3C_3C, 32'hF0_5A_0F_5F,
    32'h0F_C3_96_93, 32'h81_FF_00_81, 32'h00_00_FF_FF
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b0; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0; rw = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(1);
    // R12 reset state
    chk("R12 pin_oe", pin_oe, 8'h00);
    chk("R12 pin_out", pin_out, 8'h00);
    chk("R12 c2", {6'd0, c2_oe, c2_out}, 8'h01);
    chk("R12 irq", {6'd0, irq_c2, irq_c1}, 8'h00);
    rd_reg(4'd2, rv); chk("R12 ctrl", rv, 8'h00);
    rd_reg(4'd3, rv); chk("R12 flags", rv, 8'h00);

    // R1 R2 vector table
    for (int i = 0; i < 6; i++) begin
      wr_reg(4'd1, VEC[i][31:24]);
      wr_reg(4'd0, VEC[i][23:16]);
      pin_in = VEC[i][15:8];
      wait_n(3);
      chk("R1 pin_oe", pin_oe, VEC[i][31:24]);
      chk("R1 pin_out", pin_out, VEC[i][31:24] & VEC[i][23:16]);
      rd_reg(4'd0, rv); chk("R2 read", rv, VEC[i][7:0]);
    end
    // R1 stored value appears once the pin becomes an output
    wr_reg(4'd0, 8'h6B); chk("R1 hidden", pin_out, 8'h00);
    wr_reg(4'd1, 8'hFF); chk("R1 revealed", pin_out, 8'h6B);
    wr_reg(4'd1, 8'h00);
    rd_reg(4'd3, rv); wr_reg(4'd3, 8'h03);

    // R3 falling default
    c1_in = 1'b1; wait_n(3);
    rd_reg(4'd3, rv); chk("R3 wrong edge", rv, 8'h00);
    c1_in = 1'b0; wait_n(3);
    chk("R3 irq_c1", {7'd0, irq_c1}, 8'h01);
    rd_reg(4'd3, rv); chk("R7 read keeps", rv, 8'h01);
    // R11 alias leaves flag
    rd_reg(4'd4, rv); wr_reg(4'd4, 8'h11);
    rd_reg(4'd3, rv); chk("R11 no clear", rv, 8'h01);
    rd_reg(4'd0, rv); chk("R11 same reg", rv, 8'hFF);
    rd_reg(4'd3, rv); chk("R6 c1 clear", rv, 8'h00);
    // R3 rising select, R7 write-one clear
    wr_reg(4'd2, 8'h01);
    c1_in = 1'b1; wait_n(3);
    chk("R3 rising", {7'd0, irq_c1}, 8'h01);
    wr_reg(4'd3, 8'h01); chk("R7 wclr", {7'd0, irq_c1}, 8'h00);
    c1_in = 1'b0; wait_n(3);
    chk("R3 no fall", {7'd0, irq_c1}, 8'h00);

    // R5 rising input mode 010
    wr_reg(4'd2, 8'h04);
    c2_in = 1'b1; wait_n(3);
    chk("R5 rise flag", {6'd0, c2_oe, irq_c2}, 8'h01);
    rd_reg(4'd0, rv); rd_reg(4'd3, rv); chk("R6 c2 clear", rv, 8'h00);
    // R5 independent falling 001
    wr_reg(4'd2, 8'h02);
    c2_in = 1'b0; wait_n(3);
    rd_reg(4'd3, rv); chk("R5 ind flag", rv, 8'h02);
    rd_reg(4'd0, rv); rd_reg(4'd3, rv); chk("R6 ind keeps", rv, 8'h02);
    wr_reg(4'd3, 8'h02); rd_reg(4'd3, rv); chk("R7 c2 wclr", rv, 8'h00);

    // R8 handshake
    wr_reg(4'd2, 8'h08); wait_n(1);
    chk("R10 oe / R8 idle", {6'd0, c2_oe, c2_out}, 8'h03);
    wr_reg(4'd4, 8'h22); chk("R11 no hshake", {7'd0, c2_out}, 8'h01);
    wr_reg(4'd0, 8'h22); chk("R8 low", {7'd0, c2_out}, 8'h00);
    c1_in = 1'b1; wait_n(3); chk("R8 held", {7'd0, c2_out}, 8'h00);
    c1_in = 1'b0; wait_n(3);
    chk("R8 release", {6'd0, irq_c1, c2_out}, 8'h03);
    rd_reg(4'd0, rv); chk("R8 read low", {6'd0, irq_c1, c2_out}, 8'h00);
    c1_in = 1'b1; wait_n(3); c1_in = 1'b0; wait_n(3);
    chk("R8 release2", {7'd0, c2_out}, 8'h01);

    // R9 pulse
    wr_reg(4'd2, 8'h0A); wait_n(1);
    wr_reg(4'd0, 8'h33); chk("R9 low", {7'd0, c2_out}, 8'h00);
    wait_n(1); chk("R9 one cycle", {7'd0, c2_out}, 8'h01);

    // R10 fixed levels
    wr_reg(4'd2, 8'h0C); wait_n(1); chk("R10 low", {6'd0, c2_oe, c2_out}, 8'h02);
    wr_reg(4'd2, 8'h0E); wait_n(1); chk("R10 high", {6'd0, c2_oe, c2_out}, 8'h03);

    // R4 latching
    wr_reg(4'd2, 8'h11); wr_reg(4'd1, 8'h00);
    pin_in = 8'hA5; wait_n(3);
    c1_in = 1'b1; wait_n(3);
    pin_in = 8'h3C; wait_n(3);
    rd_reg(4'd0, rv); chk("R4 held", rv, 8'hA5);
    rd_reg(4'd0, rv); chk("R4 transparent", rv, 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule